// File: doc/BRIEF.md
# UART Loopback and Modem-Status Mirror

This block sits between a UART's register file and its receive buffer. It handles the internal self-test path that is active while software sets the loopback bit in the control register. In that mode the four modem control outputs that software drives are wired back onto the four modem status flags. The block also produces a set/clear pair that rebuilds the modem-status interrupt bits in the raw interrupt register. Every character software writes for transmission is turned around into the receive buffer. A rising send-break bit becomes a break-marked receive character. Anything arriving from the outside receiver is dropped.

With loopback off, the block gets out of the way. The status flags track the external modem pins, external characters and external break events go into the receive buffer, and transmit writes do not reach it. All outputs are registered, so every effect shows up on the cycle after the strobe that caused it.

Only one receive push can happen per cycle. A character always wins over a break marker. A break that loses waits in a single pending slot until a cycle with no character.

Top module: `uart_lpbk_mirror`

## Requirements
- R1: After reset the four status flags are 0, the loopback mode is off, and there is no push and no modem-interrupt update.
- R2: A control write with the loopback bit at 1 sets the flags one cycle later as follows: ring indicator = out2, carrier detect = out1, clear-to-send = rts, data-set-ready = dtr. This also applies to a write that only turns loopback on. The flags then hold, ignoring the pins, until the next control write.
- R3: Each control write with the loopback bit at 1 produces a one-cycle `ms_upd` pulse. On that pulse `ms_clr` is 4'hF and `ms_set` carries the new flags. Bit order in both is {ri, cts, dcd, dsr} from bit 3 down to bit 0. Otherwise all three outputs are 0.
- R4: While loopback is in effect, each transmit write causes a push one cycle later with the same data and the break marker at 0.
- R5: While loopback is in effect, external receive characters produce no push.
- R6: While loopback is in effect, a line-control write that moves the send-break bit from 0 to 1 pushes one character with data 0 and the break marker at 1. A write that keeps the bit at 1, a write that clears it, or a 0-to-1 change while loopback is off pushes nothing.
- R7: An external break event pushes a break character (data 0, marker 1) only while loopback is off. In loopback it is ignored.
- R8: While loopback is off, the flags equal the pins sampled one cycle earlier. External characters are pushed one cycle later with marker 0. Transmit writes are not pushed.
- R9: When a character and a break request fall in the same cycle, the character is pushed first and the break follows in the next cycle without a character. Break requests that arrive while one is already pending merge into one pushed break.
- R10: The loopback mode in effect is the one latched by the last control write. A control write changes the routing of characters from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_lpbk | input | 1 | Loopback bit of the written control value |
| ctl_dtr | input | 1 | DTR output bit of the written value |
| ctl_rts | input | 1 | RTS output bit of the written value |
| ctl_out1 | input | 1 | Out1 output bit of the written value |
| ctl_out2 | input | 1 | Out2 output bit of the written value |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Send-break bit of the written line-control value |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | DATA_W | Transmit character |
| ext_rx_vld | input | 1 | External receiver has a character |
| ext_rx_data | input | DATA_W | External received character |
| ext_brk_evt | input | 1 | External line-break event |
| mdm_pin_ri | input | 1 | External ring indicator pin |
| mdm_pin_dcd | input | 1 | External carrier detect pin |
| mdm_pin_cts | input | 1 | External clear-to-send pin |
| mdm_pin_dsr | input | 1 | External data-set-ready pin |
| fl_ri | output | 1 | Ring indicator status flag |
| fl_dcd | output | 1 | Carrier detect status flag |
| fl_cts | output | 1 | Clear-to-send status flag |
| fl_dsr | output | 1 | Data-set-ready status flag |
| ms_upd | output | 1 | Modem-status interrupt rebuild pulse |
| ms_clr | output | 4 | Interrupt bits to clear on the pulse |
| ms_set | output | 4 | Interrupt bits to set after clearing |
| rx_push | output | 1 | Push into the receive buffer |
| rx_push_data | output | DATA_W | Pushed character |
| rx_push_brk | output | 1 | Break marker of the pushed character |

## Verification
The assertions assume that strobes are single-cycle pulses and that the data and field inputs that go with a strobe are stable in its cycle. They make no assumption about how strobes from different sources relate, so simultaneous character and break requests are legal. The stimulus drives each strobe for exactly one clock, shortly after a rising edge. It combines strobes on purpose only in the cycles that exercise ordering (R9) and the mode switch (R10). The pins change only after an edge, so a flag sampled on the next edge sees a settled value.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;

  // Modem status vector, bit 3 down to bit 0: ri, cts, dcd, dsr
  typedef struct packed {
    logic ri;
    logic cts;
    logic dcd;
    logic dsr;
  } mdm_t;

  localparam int unsigned MDM_W = $bits(mdm_t);

  // Fixed cross-wiring of control outputs onto status inputs
  function automatic mdm_t loop_map(logic dtr, logic rts, logic out1, logic out2);
    mdm_t f;
    f.ri  = out2;
    f.cts = rts;
    f.dcd = out1;
    f.dsr = dtr;
    return f;
  endfunction

  function automatic mdm_t pin_pack(logic ri, logic dcd, logic cts, logic dsr);
    mdm_t f;
    f.ri  = ri;
    f.cts = cts;
    f.dcd = dcd;
    f.dsr = dsr;
    return f;
  endfunction

  // Interrupt rebuild: every modem bit is cleared, then the asserted flags are set again
  function automatic logic [MDM_W-1:0] irq_clr_mask(logic upd);
    return upd ? {MDM_W{1'b1}} : '0;
  endfunction

  function automatic logic [MDM_W-1:0] irq_set_mask(logic upd, mdm_t f);
    return upd ? f : '0;
  endfunction

  // Break-marked receive character: all-zero data
  function automatic logic [63:0] brk_char();
    return '0;
  endfunction

endpackage

// File: rtl/lpbk_modem_mirror.sv
module lpbk_modem_mirror
  import uart_lpbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_lpbk,
  input  logic             ctl_dtr,
  input  logic             ctl_rts,
  input  logic             ctl_out1,
  input  logic             ctl_out2,
  input  mdm_t             pins,
  output logic             lpbk_q,
  output logic             mirror_evt,
  output mdm_t             flags_q,
  output logic             upd_q,
  output logic [MDM_W-1:0] clr_q,
  output logic [MDM_W-1:0] set_q
);

  logic lpbk_nxt;
  mdm_t mapped;
  mdm_t flags_d;

  assign lpbk_nxt   = ctl_wr ? ctl_lpbk : lpbk_q;
  assign mirror_evt = ctl_wr & ctl_lpbk;
  assign mapped     = loop_map(ctl_dtr, ctl_rts, ctl_out1, ctl_out2);

  always_comb begin
    if (mirror_evt)    flags_d = mapped;
    else if (lpbk_nxt) flags_d = flags_q;
    else               flags_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lpbk_q <= 1'b0;
    else        lpbk_q <= lpbk_nxt;
  end

  // One flop per status bit
  for (genvar i = 0; i < MDM_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      clr_q <= '0;
      set_q <= '0;
    end else begin
      upd_q <= mirror_evt;
      clr_q <= irq_clr_mask(mirror_evt);
      set_q <= irq_set_mask(mirror_evt, mapped);
    end
  end

endmodule

// File: rtl/lpbk_brk_edge.sv
module lpbk_brk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lcr_wr,
  input  logic lcr_brk,
  input  logic lpbk_q,
  output logic brk_rise,
  output logic lb_brk_req
);

  logic brk_q;

  assign brk_rise   = lcr_wr & lcr_brk & ~brk_q;
  assign lb_brk_req = brk_rise & lpbk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      brk_q <= 1'b0;
    else if (lcr_wr) brk_q <= lcr_brk;
  end

endmodule

// File: rtl/lpbk_rx_arb.sv
module lpbk_rx_arb
  import uart_lpbk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lpbk_q,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ext_vld,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              ext_brk,
  input  logic              lb_brk_req,
  output logic              chr_v,
  output logic              brk_want,
  output logic              pend_q,
  output logic              push_q,
  output logic [DATA_W-1:0] push_data_q,
  output logic              push_brk_q
);

  localparam logic [DATA_W-1:0] BRK_DATA = brk_char()[DATA_W-1:0];

  logic [DATA_W-1:0] chr;
  logic              brk_new;

  // Source selection follows the mode in effect this cycle
  assign chr_v    = lpbk_q ? tx_wr   : ext_vld;
  assign chr      = lpbk_q ? tx_data : ext_data;
  assign brk_new  = lb_brk_req | (ext_brk & ~lpbk_q);
  assign brk_want = brk_new | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      push_q      <= 1'b0;
      push_data_q <= '0;
      push_brk_q  <= 1'b0;
    end else begin
      push_q <= chr_v | brk_want;
      if (chr_v) begin
        push_data_q <= chr;
        push_brk_q  <= 1'b0;
        pend_q      <= brk_want;
      end else if (brk_want) begin
        push_data_q <= BRK_DATA;
        push_brk_q  <= 1'b1;
        pend_q      <= 1'b0;
      end else begin
        push_brk_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_lpbk_mirror.sv
module uart_lpbk_mirror
  import uart_lpbk_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_lpbk,
  input  logic              ctl_dtr,
  input  logic              ctl_rts,
  input  logic              ctl_out1,
  input  logic              ctl_out2,
  input  logic              lcr_wr,
  input  logic              lcr_brk,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              ext_rx_vld,
  input  logic [DATA_W-1:0] ext_rx_data,
  input  logic              ext_brk_evt,
  input  logic              mdm_pin_ri,
  input  logic              mdm_pin_dcd,
  input  logic              mdm_pin_cts,
  input  logic              mdm_pin_dsr,
  output logic              fl_ri,
  output logic              fl_dcd,
  output logic              fl_cts,
  output logic              fl_dsr,
  output logic              ms_upd,
  output logic [3:0]        ms_clr,
  output logic [3:0]        ms_set,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_push_data,
  output logic              rx_push_brk
);

  mdm_t pins;
  mdm_t flags_q;
  logic lpbk_q;
  logic mirror_evt;
  logic brk_rise;
  logic lb_brk_req;
  logic chr_v;
  logic brk_want;
  logic pend_q;

  assign pins = pin_pack(mdm_pin_ri, mdm_pin_dcd, mdm_pin_cts, mdm_pin_dsr);

  lpbk_modem_mirror u_mirror (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_lpbk   (ctl_lpbk),
    .ctl_dtr    (ctl_dtr),
    .ctl_rts    (ctl_rts),
    .ctl_out1   (ctl_out1),
    .ctl_out2   (ctl_out2),
    .pins       (pins),
    .lpbk_q     (lpbk_q),
    .mirror_evt (mirror_evt),
    .flags_q    (flags_q),
    .upd_q      (ms_upd),
    .clr_q      (ms_clr),
    .set_q      (ms_set)
  );

  lpbk_brk_edge u_brk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lcr_wr     (lcr_wr),
    .lcr_brk    (lcr_brk),
    .lpbk_q     (lpbk_q),
    .brk_rise   (brk_rise),
    .lb_brk_req (lb_brk_req)
  );

  lpbk_rx_arb #(.DATA_W(DATA_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .lpbk_q      (lpbk_q),
    .tx_wr       (tx_wr),
    .tx_data     (tx_data),
    .ext_vld     (ext_rx_vld),
    .ext_data    (ext_rx_data),
    .ext_brk     (ext_brk_evt),
    .lb_brk_req  (lb_brk_req),
    .chr_v       (chr_v),
    .brk_want    (brk_want),
    .pend_q      (pend_q),
    .push_q      (rx_push),
    .push_data_q (rx_push_data),
    .push_brk_q  (rx_push_brk)
  );

  assign fl_ri  = flags_q.ri;
  assign fl_dcd = flags_q.dcd;
  assign fl_cts = flags_q.cts;
  assign fl_dsr = flags_q.dsr;

endmodule

// File: rtl/uart_lpbk_mirror_chk.sv
module uart_lpbk_mirror_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              ctl_lpbk,
  input logic              ctl_dtr,
  input logic              ctl_rts,
  input logic              ctl_out1,
  input logic              ctl_out2,
  input logic              tx_wr,
  input logic [DATA_W-1:0] tx_data,
  input logic              ext_rx_vld,
  input logic              mdm_pin_ri,
  input logic              mdm_pin_dcd,
  input logic              mdm_pin_cts,
  input logic              mdm_pin_dsr,
  input logic              fl_ri,
  input logic              fl_dcd,
  input logic              fl_cts,
  input logic              fl_dsr,
  input logic              ms_upd,
  input logic [3:0]        ms_clr,
  input logic [3:0]        ms_set,
  input logic              rx_push,
  input logic [DATA_W-1:0] rx_push_data,
  input logic              rx_push_brk,
  input logic              lpbk_q,
  input logic              lb_brk_req,
  input logic              pend_q
);

  p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_lpbk) |=> ({fl_ri, fl_dcd, fl_cts, fl_dsr} ==
      {$past(ctl_out2), $past(ctl_out1), $past(ctl_rts), $past(ctl_dtr)}));

  p_rebuild_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ms_upd |-> (ms_clr == 4'hF && ms_set == {fl_ri, fl_cts, fl_dcd, fl_dsr}));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_upd |-> (ms_clr == 4'h0 && ms_set == 4'h0));

  p_tx_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lpbk_q && tx_wr) |=> (rx_push && !rx_push_brk && rx_push_data == $past(tx_data)));

  p_ext_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lpbk_q && ext_rx_vld && !tx_wr && !lb_brk_req && !pend_q) |=> !rx_push);

  p_brk_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_brk |-> (rx_push && rx_push_data == '0));

  p_pins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_wr && !ctl_lpbk) || (!ctl_wr && !lpbk_q)) |=>
      ({fl_ri, fl_dcd, fl_cts, fl_dsr} ==
       {$past(mdm_pin_ri), $past(mdm_pin_dcd), $past(mdm_pin_cts), $past(mdm_pin_dsr)}));

  p_pend_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(lpbk_q ? tx_wr : ext_rx_vld)) |=> (rx_push && rx_push_brk));

endmodule

bind uart_lpbk_mirror uart_lpbk_mirror_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_wr       (ctl_wr),
  .ctl_lpbk     (ctl_lpbk),
  .ctl_dtr      (ctl_dtr),
  .ctl_rts      (ctl_rts),
  .ctl_out1     (ctl_out1),
  .ctl_out2     (ctl_out2),
  .tx_wr        (tx_wr),
  .tx_data      (tx_data),
  .ext_rx_vld   (ext_rx_vld),
  .mdm_pin_ri   (mdm_pin_ri),
  .mdm_pin_dcd  (mdm_pin_dcd),
  .mdm_pin_cts  (mdm_pin_cts),
  .mdm_pin_dsr  (mdm_pin_dsr),
  .fl_ri        (fl_ri),
  .fl_dcd       (fl_dcd),
  .fl_cts       (fl_cts),
  .fl_dsr       (fl_dsr),
  .ms_upd       (ms_upd),
  .ms_clr       (ms_clr),
  .ms_set       (ms_set),
  .rx_push      (rx_push),
  .rx_push_data (rx_push_data),
  .rx_push_brk  (rx_push_brk),
  .lpbk_q       (lpbk_q),
  .lb_brk_req   (lb_brk_req),
  .pend_q       (pend_q)
);

// File: tb/uart_lpbk_mirror_tb_top.sv
module uart_lpbk_mirror_tb_top;

  localparam int unsigned DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_lpbk = 0, ctl_dtr = 0, ctl_rts = 0, ctl_out1 = 0, ctl_out2 = 0;
  logic lcr_wr = 0, lcr_brk = 0;
  logic tx_wr = 0;
  logic [DW-1:0] tx_data = '0;
  logic ext_rx_vld = 0;
  logic [DW-1:0] ext_rx_data = '0;
  logic ext_brk_evt = 0;
  logic pin_ri = 0, pin_dcd = 0, pin_cts = 0, pin_dsr = 0;
  logic fl_ri, fl_dcd, fl_cts, fl_dsr;
  logic ms_upd;
  logic [3:0] ms_clr, ms_set;
  logic rx_push;
  logic [DW-1:0] rx_push_data;
  logic rx_push_brk;

  int checks = 0;
  int errors = 0;
  logic m_lpbk = 0;
  logic m_brk = 0;
  logic [DW:0] exp_q[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  uart_lpbk_mirror #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_lpbk(ctl_lpbk), .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
    .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
    .lcr_wr(lcr_wr), .lcr_brk(lcr_brk),
    .tx_wr(tx_wr), .tx_data(tx_data),
    .ext_rx_vld(ext_rx_vld), .ext_rx_data(ext_rx_data), .ext_brk_evt(ext_brk_evt),
    .mdm_pin_ri(pin_ri), .mdm_pin_dcd(pin_dcd), .mdm_pin_cts(pin_cts), .mdm_pin_dsr(pin_dsr),
    .fl_ri(fl_ri), .fl_dcd(fl_dcd), .fl_cts(fl_cts), .fl_dsr(fl_dsr),
    .ms_upd(ms_upd), .ms_clr(ms_clr), .ms_set(ms_set),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_brk(rx_push_brk)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_push(input logic brk, input logic [DW-1:0] d, input string tag);
    exp_q.push_back({brk, d});
    exp_tag.push_back(tag);
  endtask

  // Flags in {ri, dcd, cts, dsr} order
  task automatic chk_flags(input logic [3:0] exp, input string tag);
    chk({fl_ri, fl_dcd, fl_cts, fl_dsr} == exp, tag, {28'd0, fl_ri, fl_dcd, fl_cts, fl_dsr}, {28'd0, exp});
  endtask

  task automatic ctl(input logic lb, input logic dtr, input logic rts, input logic o1, input logic o2);
    ctl_wr = 1; ctl_lpbk = lb; ctl_dtr = dtr; ctl_rts = rts; ctl_out1 = o1; ctl_out2 = o2;
    tick();
    ctl_wr = 0;
    m_lpbk = lb;
    if (lb) begin
      chk_flags({o2, o1, rts, dtr}, "R2 mirrored flags");
      chk(ms_upd == 1'b1, "R3 update pulse", {31'd0, ms_upd}, 32'd1);
      chk(ms_clr == 4'hF, "R3 clear mask", {28'd0, ms_clr}, 32'hF);
      chk(ms_set == {o2, rts, o1, dtr}, "R3 set mask", {28'd0, ms_set}, {28'd0, o2, rts, o1, dtr});
    end else begin
      chk(ms_upd == 1'b0 && ms_set == 4'h0, "R3 no update with loopback off", {27'd0, ms_upd, ms_set}, 32'd0);
    end
  endtask

  task automatic txw(input logic [DW-1:0] d);
    tx_wr = 1; tx_data = d;
    if (m_lpbk) expect_push(1'b0, d, "R4 turned-around char");
    tick();
    tx_wr = 0;
  endtask

  task automatic extrx(input logic [DW-1:0] d);
    ext_rx_vld = 1; ext_rx_data = d;
    if (!m_lpbk) expect_push(1'b0, d, "R8 external char");
    tick();
    ext_rx_vld = 0;
  endtask

  task automatic lcr(input logic v);
    lcr_wr = 1; lcr_brk = v;
    if (v && !m_brk && m_lpbk) expect_push(1'b1, '0, "R6 loopback break char");
    m_brk = v;
    tick();
    lcr_wr = 0;
  endtask

  task automatic extbrk();
    ext_brk_evt = 1;
    if (!m_lpbk) expect_push(1'b1, '0, "R7 external break char");
    tick();
    ext_brk_evt = 0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected push", {23'd0, rx_push_brk, rx_push_data}, 32'hFFFF_FFFF);
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk({rx_push_brk, rx_push_data} == e, t, {23'd0, rx_push_brk, rx_push_data}, {23'd0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk_flags(4'b0000, "R1 flags after reset");
    chk(ms_upd == 0 && rx_push == 0, "R1 idle outputs", {30'd0, ms_upd, rx_push}, 32'd0);
    rst_n = 1;
    tick();

    // R8 pins pass through with loopback off
    pin_ri = 1; pin_dcd = 0; pin_cts = 1; pin_dsr = 0;
    tick();
    chk_flags(4'b1010, "R8 flags follow pins");
    pin_ri = 0; pin_dcd = 1; pin_cts = 0; pin_dsr = 1;
    tick();
    chk_flags(4'b0101, "R8 flags follow new pins");
    extrx(8'h3C);
    txw(8'h77);       // not pushed: R8
    extbrk();         // R7 pushed with loopback off
    ctl(1'b0, 1, 1, 1, 1);   // R3 no update
    tick();

    // R10: control write enabling loopback, external char in same cycle still routed
    ext_rx_vld = 1; ext_rx_data = 8'hA5;
    expect_push(1'b0, 8'hA5, "R10 old mode in write cycle");
    ctl(1'b1, 0, 0, 0, 0);
    ext_rx_vld = 0;
    tick();

    // R2 R3 mirror patterns
    ctl(1'b1, 1, 0, 0, 0);
    ctl(1'b1, 0, 1, 0, 0);
    ctl(1'b1, 0, 0, 1, 0);
    ctl(1'b1, 0, 0, 0, 1);
    ctl(1'b1, 1, 0, 1, 1);
    pin_ri = 0; pin_dcd = 0; pin_cts = 1; pin_dsr = 0;
    tick(); tick();
    chk_flags(4'b1101, "R2 flags hold, pins ignored");

    // R4 R5 loopback data
    txw(8'h11);
    txw(8'hFE);
    extrx(8'h99);     // dropped
    extbrk();         // R7 ignored in loopback
    tick(); tick();
    chk(exp_q.size() == 0, "R5 nothing outstanding", exp_q.size(), 0);

    // R6 break edges
    lcr(1'b1);
    lcr(1'b1);
    lcr(1'b0);
    tick();

    // R9 ordering and merge
    tx_data = 8'h21; tx_wr = 1; lcr_wr = 1; lcr_brk = 1; m_brk = 1;
    expect_push(1'b0, 8'h21, "R9 char before break");
    tick();
    lcr_brk = 0; m_brk = 0; tx_data = 8'h22;
    expect_push(1'b0, 8'h22, "R9 second char");
    tick();
    lcr_brk = 1; m_brk = 1; tx_data = 8'h23;
    expect_push(1'b0, 8'h23, "R9 third char");
    expect_push(1'b1, '0, "R9 merged break");
    tick();
    tx_wr = 0; lcr_wr = 0;
    tick(); tick();

    // R6 break rise with loopback off pushes nothing; R10 tx after leaving loopback
    lcr(1'b0);
    ctl(1'b0, 0, 0, 0, 0);
    lcr(1'b1);
    txw(8'h55);
    tick();
    chk_flags({pin_ri, pin_dcd, pin_cts, pin_dsr}, "R8 flags back on pins");

    // R9 external char and break together
    ext_rx_vld = 1; ext_rx_data = 8'h44; ext_brk_evt = 1;
    expect_push(1'b0, 8'h44, "R9 external char first");
    expect_push(1'b1, '0, "R9 external break second");
    tick();
    ext_rx_vld = 0; ext_brk_evt = 0;

    repeat (5) tick();
    chk(exp_q.size() == 0, "R9 all expected pushes seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule